// File: doc/BRIEF.md
# SEC-DED Memory Error Correction Controller

This block sits between a 16-bit processor bus and a static RAM whose words are 22 bits wide: 16 data bits plus 6 check bits. On a write it computes the check bits with a single-error-correcting, double-error-detecting Hamming code and stores the full code word. On a read it recomputes the check bits, XORs them with the stored ones to form a syndrome, and decides whether the word is clean, holds a single-bit error, or holds an error it cannot correct.

A single-bit error is corrected on the fly. The corrected code word is written back to the same RAM address in the cycle that acknowledges the read, so the bus cycle is not stretched. The event sets a sticky interrupt and increments a count of corrected errors. An uncorrectable word asserts a bus-error output, which the system uses to reset the processor. It also emits a one-cycle log strobe with the failing address, so a battery-backed store outside the block can keep a record. For testing there are two controls. A bypass switch makes reads return raw data with no correction and no reporting. An injection control flips one or two chosen code-word bits on the way to RAM.

Top module: `edac_ctrl`

## Requirements
- R1: A write stores data in code-word bits [15:0] and check bits in [21:16]. Data bit k takes the k-th Hamming position in ascending order that is not a power of two: 3, 5, 6, 7, 9..15, 17..21. Check bit i (i<5) is the XOR of bit i of the positions of all data bits that are 1. Check bit 5 is the even parity of data and check bits 4..0.
- R2: A read of an error-free word returns the written data, with no write-back, no bus error and no interrupt.
- R3: When the syndrome points at a data bit, the read returns the corrected data. The corrected code word is written to the same address in the acknowledge cycle.
- R4: When the syndrome points at a check bit (bits 16..21), the data is returned unchanged and the check bits are rewritten to their correct values.
- R5: Every corrected read sets sbe_irq_o one cycle after the acknowledge. It stays set until a cycle with irq_clr_i high, and a new event in that same cycle keeps it set.
- R6: corr_cnt_o starts at 0 after reset and rises by one for each corrected read. It holds at its maximum value.
- R7: An uncorrectable word (two bit errors) drives bus_err_o high in the acknowledge cycle. It returns the raw data, writes nothing back, and leaves the interrupt and the counter unchanged.
- R8: Every bus error pulses log_we_o in the same cycle, with log_addr_o equal to the failing read address.
- R9: With inj_en_i high, a write flips code-word bit inj_pos_i. If inj_dbl_i is also high, it flips bit inj_pos_i+1 as well, wrapping from 21 to 0.
- R10: With edac_dis_i high, a read returns raw bits [15:0] and raises no write-back, no interrupt and no bus error.
- R11: A write is acknowledged in the cycle its request is presented. A read is acknowledged one cycle after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Transfer acknowledge |
| rdata_o | output | 16 | Read data, valid with ack_o on a read |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | 22 | Code word to RAM |
| mem_rdata_i | input | 22 | Code word from RAM, one cycle after mem_en_o |
| edac_dis_i | input | 1 | Bypass checking and correction |
| inj_en_i | input | 1 | Enable error injection on writes |
| inj_dbl_i | input | 1 | Inject a second, adjacent bit |
| inj_pos_i | input | 5 | Code-word bit to flip |
| irq_clr_i | input | 1 | Clear the corrected-error interrupt |
| sbe_irq_o | output | 1 | Corrected-error interrupt |
| corr_cnt_o | output | CNT_W | Corrected-error count |
| bus_err_o | output | 1 | Uncorrectable error |
| log_we_o | output | 1 | Error-log write strobe |
| log_addr_o | output | ADDR_W | Address for the error log |

## Verification
The single-error tests flip each of the 22 code-word bits in turn. This separates a wrong data-bit position map (the wrong data bit is repaired) from a wrong check-bit decode (the stored word is not restored). Several data patterns, including all zeros and all ones, show whether the check-bit equations are built correctly. Double errors, including the injection case that wraps from bit 21 to bit 0, show whether a two-bit error is reported as an uncorrectable fault or wrongly treated as a correction. Repeating corrupted reads with the bypass switch set shows whether the bypass path still writes back or raises an error.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DW  = 16;
  localparam int HW  = 5;
  localparam int CW  = HW + 1;
  localparam int WW  = DW + CW;
  localparam int PW  = $clog2(WW);

  typedef enum logic {ST_IDLE, ST_CHK} edac_st_e;

  function automatic logic pos_is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // data bit index held at Hamming position p (p not a power of two)
  function automatic int data_idx(int p);
    int n;
    n = 0;
    for (int i = 0; i < HW; i++) if ((1 << i) <= p) n++;
    return p - n - 1;
  endfunction

  // data bits covered by Hamming check bit i
  function automatic logic [DW-1:0] chk_mask(int i);
    logic [DW-1:0] m;
    m = '0;
    for (int p = 1; p < WW; p++)
      if (!pos_is_pow2(p) && ((p >> i) & 1) == 1) m[data_idx(p)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
  import edac_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [HW-1:0] ham;

  for (genvar g = 0; g < HW; g++) begin : g_chk
    assign ham[g] = ^(data_i & chk_mask(g));
  end

  assign chk_o = {^{data_i, ham}, ham};
endmodule

// File: rtl/edac_inject.sv
module edac_inject
  import edac_pkg::*;
(
  input  logic [WW-1:0] code_i,
  input  logic          en_i,
  input  logic          dbl_i,
  input  logic [PW-1:0] pos_i,
  output logic [WW-1:0] code_o
);
  logic [PW-1:0] nxt;
  logic [WW-1:0] mask;

  assign nxt = (pos_i == PW'(WW - 1)) ? '0 : pos_i + 1'b1;

  for (genvar g = 0; g < WW; g++) begin : g_mask
    assign mask[g] = en_i && ((pos_i == PW'(g)) || (dbl_i && nxt == PW'(g)));
  end

  assign code_o = code_i ^ mask;
endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
  import edac_pkg::*;
(
  input  logic [WW-1:0] code_i,
  output logic [WW-1:0] code_o,
  output logic          sbe_o,
  output logic          dbe_o
);
  logic [CW-1:0] re_chk;
  logic [HW-1:0] syn;
  logic          par;
  logic [WW-1:0] flip;

  edac_encoder u_enc (.data_i(code_i[DW-1:0]), .chk_o(re_chk));

  assign syn = code_i[DW +: HW] ^ re_chk[HW-1:0];
  assign par = ^code_i;

  always_comb begin
    flip  = '0;
    sbe_o = 1'b0;
    dbe_o = 1'b0;
    if (par) begin
      sbe_o = 1'b1;
      if (syn == '0) begin
        flip[WW-1] = 1'b1;
      end else if (pos_is_pow2(int'(syn))) begin
        for (int i = 0; i < HW; i++) if (syn == HW'(1 << i)) flip[DW+i] = 1'b1;
      end else if (int'(syn) < WW) begin
        flip[data_idx(int'(syn))] = 1'b1;
      end else begin
        sbe_o = 1'b0;
        dbe_o = 1'b1;
      end
    end else if (syn != '0) begin
      dbe_o = 1'b1;
    end
  end

  assign code_o = code_i ^ flip;

  assert_sbe_dbe_excl_R7: assert final (!(sbe_o && dbe_o));
endmodule

// File: rtl/edac_err_report.sv
module edac_err_report #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      if (evt_i)      irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
      if (evt_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1));
  assert_irq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/edac_ctrl.sv
module edac_ctrl
  import edac_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic              ack_o,
  output logic [15:0]       rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [21:0]       mem_wdata_o,
  input  logic [21:0]       mem_rdata_i,
  input  logic              edac_dis_i,
  input  logic              inj_en_i,
  input  logic              inj_dbl_i,
  input  logic [4:0]        inj_pos_i,
  input  logic              irq_clr_i,
  output logic              sbe_irq_o,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic              bus_err_o,
  output logic              log_we_o,
  output logic [ADDR_W-1:0] log_addr_o
);
  edac_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     wr_chk;
  logic [WW-1:0]     wr_code, dec_code;
  logic              dec_sbe, dec_dbe, fix, sbe_evt;

  edac_encoder u_enc (.data_i(wdata_i), .chk_o(wr_chk));

  edac_inject u_inj (
    .code_i ({wr_chk, wdata_i}),
    .en_i   (inj_en_i),
    .dbl_i  (inj_dbl_i),
    .pos_i  (inj_pos_i),
    .code_o (wr_code)
  );

  edac_decoder u_dec (
    .code_i (mem_rdata_i),
    .code_o (dec_code),
    .sbe_o  (dec_sbe),
    .dbe_o  (dec_dbe)
  );

  assign fix     = (st_q == ST_CHK) && dec_sbe && !edac_dis_i;
  assign sbe_evt = fix;

  edac_err_report #(.CNT_W(CNT_W)) u_rep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (sbe_evt),
    .clr_i  (irq_clr_i),
    .irq_o  (sbe_irq_o),
    .cnt_o  (corr_cnt_o)
  );

  always_comb begin
    st_d        = st_q;
    ack_o       = 1'b0;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_i;
    mem_wdata_o = wr_code;
    bus_err_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          mem_en_o = 1'b1;
          mem_we_o = we_i;
          ack_o    = we_i;
          if (!we_i) st_d = ST_CHK;
        end
      end
      ST_CHK: begin
        ack_o       = 1'b1;
        mem_addr_o  = addr_q;
        mem_wdata_o = dec_code;
        mem_en_o    = fix;
        mem_we_o    = fix;
        bus_err_o   = dec_dbe && !edac_dis_i;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // raw bits when bypassed or uncorrectable
  assign rdata_o    = (edac_dis_i || dec_dbe) ? mem_rdata_i[DW-1:0] : dec_code[DW-1:0];
  assign log_we_o   = bus_err_o;
  assign log_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) addr_q <= addr_i;
    end
  end

  assert_wb_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && dec_sbe && !edac_dis_i) |-> (mem_we_o && mem_addr_o == addr_q));
  assert_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && mem_we_o) |=> sbe_irq_o);
  assert_berr_nowb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (ack_o && !mem_we_o));
  assert_log_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (log_we_o && log_addr_o == addr_q));
  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHK && edac_dis_i) |-> (!mem_we_o && !bus_err_o));
  assert_rd_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && !we_i) |=> ack_o);
endmodule

// File: tb/tb_edac_ctrl.sv
module tb_edac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int CNTW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack, mem_en, mem_we, bus_err, log_we, sbe_irq;
  logic [15:0] rdata;
  logic [AW-1:0] mem_addr, log_addr;
  logic [21:0] mem_wdata, mem_rdata;
  logic dis = 1'b0, inj_en = 1'b0, inj_dbl = 1'b0, irq_clr = 1'b0;
  logic [4:0] inj_pos = '0;
  logic [CNTW-1:0] corr_cnt;

  int checks = 0, fails = 0, ecnt = 0;

  logic [21:0] mem [64];
  logic cor_go = 1'b0;
  logic [5:0] cor_a = '0;
  logic [21:0] cor_m = '0;

  // captured in the acknowledge cycle of a read
  logic r_ack, r_berr, r_logwe, r_memwe;
  logic [15:0] r_data;
  logic [AW-1:0] r_logaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  edac_ctrl #(.ADDR_W(AW), .CNT_W(CNTW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .edac_dis_i(dis), .inj_en_i(inj_en),
    .inj_dbl_i(inj_dbl), .inj_pos_i(inj_pos), .irq_clr_i(irq_clr),
    .sbe_irq_o(sbe_irq), .corr_cnt_o(corr_cnt), .bus_err_o(bus_err),
    .log_we_o(log_we), .log_addr_o(log_addr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (mem_en) begin
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[5:0]];
      end
      if (cor_go) mem[cor_a] <= mem[cor_a] ^ cor_m;
    end
  end

  function automatic logic [21:0] tb_code(logic [15:0] d);
    logic [5:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < 22; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) c[4:0] ^= 5'(p);
        k++;
      end
    end
    c[5] = ^{d, c[4:0]};
    return {c, d};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    #1 chk("R11 write ack", 32'(ack), 32'd1);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(logic [5:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #1 chk("R11 no read ack in request cycle", 32'(ack), 32'd0);
    @(negedge clk);
    req = 1'b0;
    r_ack = ack; r_data = rdata; r_berr = bus_err;
    r_logwe = log_we; r_logaddr = log_addr; r_memwe = mem_we;
    @(negedge clk);
  endtask

  task automatic corrupt(logic [5:0] a, logic [21:0] m);
    @(negedge clk);
    cor_go = 1'b1; cor_a = a; cor_m = m;
    @(negedge clk);
    cor_go = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 irq after reset", 32'(sbe_irq), 32'd0);
    chk("R6 count after reset", 32'(corr_cnt), 32'd0);
    chk("R7 bus_err after reset", 32'(bus_err), 32'd0);
    chk("R11 ack after reset", 32'(ack), 32'd0);
  endtask

  task automatic t_clean();
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234};
    foreach (pats[i]) begin
      do_write(6'(i + 1), pats[i]);
      chk("R1 stored code word", 32'(mem[i + 1]), 32'(tb_code(pats[i])));
      do_read(6'(i + 1));
      chk("R11 read ack", 32'(r_ack), 32'd1);
      chk("R2 clean data", 32'(r_data), 32'(pats[i]));
      chk("R2 no write-back", 32'(r_memwe), 32'd0);
      chk("R2 no bus error", 32'(r_berr), 32'd0);
    end
    chk("R2 no irq", 32'(sbe_irq), 32'd0);
  endtask

  task automatic t_single();
    logic [15:0] d = 16'h6B2D;
    for (int b = 0; b < 22; b++) begin
      do_write(6'd10, d);
      corrupt(6'd10, 22'(1) << b);
      do_read(6'd10);
      ecnt++;
      if (b < 16) begin
        chk("R3 corrected data", 32'(r_data), 32'(d));
        chk("R3 write-back strobe", 32'(r_memwe), 32'd1);
        chk("R3 word restored", 32'(mem[10]), 32'(tb_code(d)));
      end else begin
        chk("R4 data unchanged", 32'(r_data), 32'(d));
        chk("R4 check bits rewritten", 32'(mem[10]), 32'(tb_code(d)));
      end
      chk("R5 irq set", 32'(sbe_irq), 32'd1);
      chk("R6 count", 32'(corr_cnt), 32'(ecnt));
    end
    do_read(6'd1);
    chk("R5 irq sticky", 32'(sbe_irq), 32'd1);
    clear_irq();
    chk("R5 irq cleared", 32'(sbe_irq), 32'd0);
  endtask

  task automatic t_irq_priority();
    do_write(6'd11, 16'h0F0F);
    corrupt(6'd11, 22'h000040);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(11);
    @(negedge clk);
    req = 1'b0; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    ecnt++;
    chk("R5 set wins over clear", 32'(sbe_irq), 32'd1);
    clear_irq();
  endtask

  task automatic t_double();
    logic [15:0] d = 16'h3C96;
    do_write(6'd7, d);
    corrupt(6'd7, 22'h000204);
    do_read(6'd7);
    chk("R7 bus error", 32'(r_berr), 32'd1);
    chk("R7 raw data", 32'(r_data), 32'(d ^ 16'h0204));
    chk("R7 no write-back", 32'(r_memwe), 32'd0);
    chk("R7 word unchanged", 32'(mem[7]), 32'(tb_code(d) ^ 22'h000204));
    chk("R7 no irq", 32'(sbe_irq), 32'd0);
    chk("R6 count unchanged", 32'(corr_cnt), 32'(ecnt));
    chk("R8 log strobe", 32'(r_logwe), 32'd1);
    chk("R8 log address", 32'(r_logaddr), 32'd7);
  endtask

  task automatic t_inject();
    logic [15:0] d = 16'hBEEF;
    inj_en = 1'b1; inj_pos = 5'd5;
    do_write(6'd20, d);
    inj_en = 1'b0;
    chk("R9 single inject stored", 32'(mem[20]), 32'(tb_code(d) ^ 22'h000020));
    do_read(6'd20);
    ecnt++;
    chk("R9 single inject corrected", 32'(r_data), 32'(d));
    chk("R9 single inject restored", 32'(mem[20]), 32'(tb_code(d)));
    clear_irq();
    inj_en = 1'b1; inj_dbl = 1'b1; inj_pos = 5'd21;
    do_write(6'd21, d);
    inj_en = 1'b0; inj_dbl = 1'b0;
    chk("R9 double inject wraps", 32'(mem[21]), 32'(tb_code(d) ^ 22'h200001));
    do_read(6'd21);
    chk("R9 double inject bus error", 32'(r_berr), 32'd1);
    chk("R8 log address inject", 32'(r_logaddr), 32'd21);
  endtask

  task automatic t_bypass();
    logic [15:0] d = 16'h5A5A;
    dis = 1'b1;
    do_write(6'd30, d);
    corrupt(6'd30, 22'h000008);
    do_read(6'd30);
    chk("R10 raw data", 32'(r_data), 32'(d ^ 16'h0008));
    chk("R10 no write-back", 32'(r_memwe), 32'd0);
    chk("R10 word left corrupted", 32'(mem[30]), 32'(tb_code(d) ^ 22'h000008));
    chk("R10 no irq", 32'(sbe_irq), 32'd0);
    chk("R10 count unchanged", 32'(corr_cnt), 32'(ecnt));
    corrupt(6'd30, 22'h000100);
    do_read(6'd30);
    chk("R10 no bus error", 32'(r_berr), 32'd0);
    chk("R10 no log", 32'(r_logwe), 32'd0);
    dis = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_irq_priority();
    t_double();
    t_inject();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule